// File: doc/BRIEF.md
# IPv4 Tunnel Decapsulator

This block sits at the exit of an IPv6-in-IPv4 tunnel. It takes a stream of 32-bit words in which every packet is marked by a start-of-frame and an end-of-frame flag, with a byte count on the last word. For each IPv4 packet it reads the header and picks one of three outcomes. If the packet is a valid tunnel packet aimed at this endpoint, the block removes the whole IPv4 header, options included, and sends the inner IPv6 packet. If the header checksum is wrong, the packet is discarded and an error counter goes up. In every other case the packet passes through untouched.

Every word leaves the block a fixed number of cycles after it enters. During that time the header is parsed. Each packet's outcome waits in a small ticket queue until the packet's first word reaches the output stage. The local endpoint address is held in a register that software writes through a one-cycle write strobe. A new value is applied only when the next packet starts, so one packet is never judged against two different addresses.

Top module: `v6in4_decap`

## Requirements
- R1: After reset, `out_valid` is low, `err_count` is zero and the local endpoint address equals the parameter `LOCAL_RESET`.
- R2: A packet is decapsulated when all of the following hold:
  - the version (word 0 bits [31:28]) is 4;
  - the header length in 32-bit words, IHL (word 0 bits [27:24]), is at least 5;
  - the protocol (word 2 bits [23:16]) is 41;
  - the destination (word 4) equals the local address;
  - the header checksum verifies;
  - the packet is not a fragment;
  - at least one word follows the header.

  Words 0 to IHL-1 are removed. Word IHL leaves with the start-of-frame flag set, and the last word keeps its end-of-frame flag and byte count.
- R3: Header options are removed as well. For IHL from 6 to 15, exactly IHL words are stripped.
- R4: A packet whose protocol field is not 41 is forwarded unchanged.
- R5: A packet whose destination differs from the local address is forwarded unchanged.
- R6: A fragment is forwarded unchanged. A packet counts as a fragment when either the more-fragments bit (word 1 bit 13) is set or the fragment offset (word 1 bits [12:0]) is nonzero.
- R7: A packet is dropped entirely when it has version 4, IHL of at least 5 and a complete header, and the ones'-complement sum of the 16-bit halves of its IHL header words is not 0xFFFF. Each drop adds one to `err_count`, which saturates at its maximum.
- R8: The following are forwarded unchanged:
  - a packet whose version is not 4;
  - a packet whose IHL is below 5;
  - a packet that ends before its header is complete;
  - a valid tunnel packet with no word after the header.
- R9: Each output word appears exactly `DLY_DEPTH`+1 cycles after the matching input word. Order and idle gaps are preserved, and no output word exists without an input word.
- R10: A write to the local address takes effect for the first packet whose start word is sampled after the write cycle. A write in the same cycle as a start word does not affect that packet.
- R11: Back-to-back packets with no idle cycle between them, including single-word packets, are each judged separately and correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | First word of a packet |
| in_eof | input | 1 | Last word of a packet |
| in_bcnt | input | 3 | Valid bytes in the word (1 to 4; 4 on non-last words) |
| in_data | input | 32 | Input word, first byte in bits [31:24] |
| cfg_we | input | 1 | Write strobe for the local endpoint address |
| cfg_addr | input | 32 | New local endpoint address |
| out_valid | output | 1 | Output word present |
| out_sof | output | 1 | First word of an output packet |
| out_eof | output | 1 | Last word of an output packet |
| out_bcnt | output | 3 | Valid bytes in the output word |
| out_data | output | 32 | Output word |
| err_count | output | ERR_W | Saturating count of checksum drops |

## Verification
The bench targets several corner cases. The first is the header length at its smallest value and at its largest, 15. A design that strips a fixed five words would leak option words or cut into the inner packet. Fragments, a wrong protocol, a wrong destination and a corrupted checksum are each sent alone, so a design that checks only some of the header fields would wrongly decapsulate one of them. Truncated packets and packets that end exactly at the header test whether the block waits for a header that never completes or emits an empty inner packet. Address writes are placed just before a start word and in the same cycle as one, and single-word packets arrive back to back. A design that applies the address immediately, or mixes up verdicts between packets, would then send the wrong packet on the wrong path.

// File: rtl/v6in4_pkg.sv
package v6in4_pkg;
  localparam int WORD_W = 32;
  localparam int BCNT_W = 3;
  localparam int IHL_W  = 4;

  typedef enum logic [1:0] {
    VERD_FWD   = 2'd0,
    VERD_DECAP = 2'd1,
    VERD_DROP  = 2'd2
  } verdict_e;

  typedef struct packed {
    logic              vld;
    logic              sof;
    logic              eof;
    logic [BCNT_W-1:0] bcnt;
    logic [WORD_W-1:0] data;
  } beat_t;

  typedef struct packed {
    verdict_e         verd;
    logic [IHL_W-1:0] ihl;
  } ticket_t;
endpackage

// File: rtl/v6in4_hdr_check.sv
module v6in4_hdr_check
  import v6in4_pkg::*;
#(
  parameter logic [7:0] TUN_PROTO = 8'd41,
  parameter int         ERR_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] local_addr,
  output logic              tk_push,
  output ticket_t           tk_data,
  output logic [ERR_W-1:0]  err_count
);
  localparam int ACC_W = 21;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [IDX_W-1:0] widx_q, idx;
  logic [IHL_W-1:0] ihl_q, ihl_c;
  logic             qual_q, qual_c, frag_q, frag_c, proto_q, proto_c;
  logic             dst_q, dst_c, done_q, done_c, first, hdr_end, sum_ok;
  logic [ACC_W-1:0] acc_q, acc_c;
  logic [16:0]      fold1;
  logic [15:0]      fold2;
  logic [ERR_W-1:0] err_q;
  verdict_e         verd;

  always_comb begin
    first   = in_vld && in_sof;
    idx     = first ? '0 : widx_q;
    ihl_c   = first ? in_data[27:24] : ihl_q;
    qual_c  = first ? (in_data[31:28] == 4'd4 && in_data[27:24] >= 4'd5) : qual_q;
    acc_c   = (first ? '0 : acc_q) + ACC_W'(in_data[31:16]) + ACC_W'(in_data[15:0]);
    frag_c  = (idx == 4'd1) ? (in_data[13] || (|in_data[12:0])) : frag_q;
    proto_c = (idx == 4'd2) ? (in_data[23:16] == TUN_PROTO) : proto_q;
    dst_c   = (idx == 4'd4) ? (in_data == local_addr) : dst_q;
    done_c  = first ? 1'b0 : done_q;
    fold1   = {1'b0, acc_c[15:0]} + 17'(acc_c[ACC_W-1:16]);
    fold2   = fold1[15:0] + 16'(fold1[16]);
    sum_ok  = (fold2 == 16'hFFFF);
    hdr_end = qual_c && (idx == IDX_W'(ihl_c - 4'd1));
    tk_push = 1'b0;
    verd    = VERD_FWD;
    if (in_vld && !done_c) begin
      if (!qual_c) begin
        tk_push = 1'b1;
      end else if (hdr_end) begin
        tk_push = 1'b1;
        if (!sum_ok)                                   verd = VERD_DROP;
        else if (proto_c && dst_c && !frag_c && !in_eof) verd = VERD_DECAP;
      end else if (in_eof) begin
        tk_push = 1'b1;
      end
    end
    tk_data = '{verd: verd, ihl: ihl_c};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      widx_q  <= '0;
      ihl_q   <= '0;
      qual_q  <= 1'b0;
      frag_q  <= 1'b0;
      proto_q <= 1'b0;
      dst_q   <= 1'b0;
      done_q  <= 1'b1;
      acc_q   <= '0;
      err_q   <= '0;
    end else if (in_vld) begin
      widx_q  <= (idx == IDX_MAX) ? IDX_MAX : idx + 1'b1;
      ihl_q   <= ihl_c;
      qual_q  <= qual_c;
      frag_q  <= frag_c;
      proto_q <= proto_c;
      dst_q   <= dst_c;
      done_q  <= done_c || tk_push;
      acc_q   <= acc_c;
      if (tk_push && verd == VERD_DROP && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end
  end

  assign err_count = err_q;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (tk_push && !(in_vld && in_sof)) |-> !$past(tk_push)); // R11
  AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_q >= $past(err_q))); // R7
endmodule

// File: rtl/v6in4_ticket_fifo.sv
module v6in4_ticket_fifo
  import v6in4_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  ticket_t wdata,
  input  logic    pop,
  output ticket_t head
);
  localparam int AW = $clog2(DEPTH);

  ticket_t       mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          full, empty;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign head  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  AST_TICKET_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R11
  AST_TICKET_READY_AT_SOF: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R9
endmodule

// File: rtl/v6in4_delay.sv
module v6in4_delay
  import v6in4_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  beat_t din,
  output beat_t dout
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  beat_t         mem [DEPTH];
  beat_t         rd_c;
  logic [PW-1:0] wp;
  logic          primed;

  always_ff @(posedge clk) begin
    mem[wp] <= din;
  end

  always_comb begin
    rd_c     = mem[wp];
    rd_c.vld = rd_c.vld && primed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      primed <= 1'b0;
      dout   <= '0;
    end else begin
      wp     <= (wp == LAST) ? '0 : wp + 1'b1;
      primed <= primed || (wp == LAST);
      dout   <= rd_c;
    end
  end
endmodule

// File: rtl/v6in4_emit.sv
module v6in4_emit
  import v6in4_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  beat_t   rd,
  input  ticket_t head,
  output logic    pop,
  output beat_t   obeat
);
  localparam int JW = 5;
  localparam logic [JW-1:0] JMAX = '1;

  verdict_e         cur_verd, verd_w;
  logic [IHL_W-1:0] cur_ihl, ihl_w;
  logic [JW-1:0]    j_q, jw;
  logic             start, emit, osof;

  always_comb begin
    start  = rd.vld && rd.sof;
    pop    = start;
    verd_w = start ? head.verd : cur_verd;
    ihl_w  = start ? head.ihl  : cur_ihl;
    jw     = start ? '0 : j_q;
    emit   = 1'b0;
    osof   = 1'b0;
    case (verd_w)
      VERD_FWD: begin
        emit = 1'b1;
        osof = rd.sof;
      end
      VERD_DECAP: begin
        emit = (jw >= JW'(ihl_w));
        osof = (jw == JW'(ihl_w));
      end
      default: begin
        emit = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obeat    <= '0;
      cur_verd <= VERD_DROP;
      cur_ihl  <= '0;
      j_q      <= JMAX;
    end else begin
      obeat.vld  <= rd.vld && emit;
      obeat.sof  <= rd.vld && emit && osof;
      obeat.eof  <= rd.vld && emit && rd.eof;
      obeat.bcnt <= rd.bcnt;
      obeat.data <= rd.data;
      if (rd.vld) begin
        cur_verd <= verd_w;
        cur_ihl  <= ihl_w;
        j_q      <= (jw == JMAX) ? JMAX : jw + 1'b1;
      end
    end
  end

  AST_IDLE_IN_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !rd.vld |=> !obeat.vld); // R9
endmodule

// File: rtl/v6in4_decap.sv
module v6in4_decap
  import v6in4_pkg::*;
#(
  parameter logic [WORD_W-1:0] LOCAL_RESET  = 32'h0A00_0001,
  parameter logic [7:0]        TUN_PROTO    = 8'd41,
  parameter int                DLY_DEPTH    = 16,
  parameter int                TICKET_DEPTH = 32,
  parameter int                ERR_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BCNT_W-1:0] in_bcnt,
  input  logic [WORD_W-1:0] in_data,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_addr,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [BCNT_W-1:0] out_bcnt,
  output logic [WORD_W-1:0] out_data,
  output logic [ERR_W-1:0]  err_count
);
  logic [WORD_W-1:0] addr_pend, addr_live;
  beat_t             in_beat, rd_beat, out_beat;
  ticket_t           tk_wdata, tk_head;
  logic              tk_push, tk_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_pend <= LOCAL_RESET;
      addr_live <= LOCAL_RESET;
    end else begin
      if (cfg_we)              addr_pend <= cfg_addr;
      if (in_valid && in_sof)  addr_live <= addr_pend;
    end
  end

  assign in_beat = '{vld: in_valid, sof: in_sof, eof: in_eof, bcnt: in_bcnt, data: in_data};

  v6in4_hdr_check #(.TUN_PROTO(TUN_PROTO), .ERR_W(ERR_W)) u_check (
    .clk(clk), .rst(rst), .in_vld(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .local_addr(addr_live), .tk_push(tk_push), .tk_data(tk_wdata),
    .err_count(err_count)
  );

  v6in4_ticket_fifo #(.DEPTH(TICKET_DEPTH)) u_tickets (
    .clk(clk), .rst(rst), .push(tk_push), .wdata(tk_wdata), .pop(tk_pop), .head(tk_head)
  );

  v6in4_delay #(.DEPTH(DLY_DEPTH)) u_delay (
    .clk(clk), .rst(rst), .din(in_beat), .dout(rd_beat)
  );

  v6in4_emit u_emit (
    .clk(clk), .rst(rst), .rd(rd_beat), .head(tk_head), .pop(tk_pop), .obeat(out_beat)
  );

  assign out_valid = out_beat.vld;
  assign out_sof   = out_beat.sof;
  assign out_eof   = out_beat.eof;
  assign out_bcnt  = out_beat.bcnt;
  assign out_data  = out_beat.data;

  AST_ADDR_HELD_MID_PACKET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sof) |=> $stable(addr_live)); // R10
endmodule

// File: tb/v6in4_decap_tb.sv
module v6in4_decap_tb;
  localparam int LAT = 17;
  localparam int ERRW = 2;
  localparam int MAXE = 3;
  localparam int NC = 8192;
  localparam logic [31:0] ADDR0 = 32'h0A00_0001;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_sof, in_eof, cfg_we;
  logic [2:0] in_bcnt;
  logic [31:0] in_data, cfg_addr;
  logic out_valid, out_sof, out_eof;
  logic [2:0] out_bcnt;
  logic [31:0] out_data;
  logic [ERRW-1:0] err_count;

  always #5 clk = ~clk;

  v6in4_decap #(.LOCAL_RESET(ADDR0), .ERR_W(ERRW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_bcnt(in_bcnt), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_bcnt(out_bcnt),
    .out_data(out_data), .err_count(err_count)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          ev [NC];
  logic [31:0] ed [NC];
  bit          es [NC];
  bit          ee [NC];
  logic [2:0]  ec [NC];

  int n_chk = 0, n_bad = 0;
  string phase = "R1";
  bit chk_on = 0;
  logic [31:0] m_pend, m_live;
  int m_err;
  logic [31:0] pkt[$];

  always @(negedge clk) begin
    if (chk_on && cyc < NC) begin
      n_chk++;
      if (out_valid !== ev[cyc] ||
          (ev[cyc] && (out_data !== ed[cyc] || out_sof !== es[cyc] ||
                       out_eof !== ee[cyc] || out_bcnt !== ec[cyc]))) begin
        n_bad++;
        $display("FAIL R9/%s cycle %0d: got v%0b d%h s%0b e%0b c%0d, expected v%0b d%h s%0b e%0b c%0d",
                 phase, cyc, out_valid, out_data, out_sof, out_eof, out_bcnt,
                 ev[cyc], ed[cyc], es[cyc], ee[cyc], ec[cyc]);
      end
    end
  end

  function automatic logic [15:0] hsum(int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += int'(pkt[i][31:16]) + int'(pkt[i][15:0]);
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return 16'(s);
  endfunction

  function automatic int verdict(logic [31:0] live);
    int n = pkt.size();
    int ihl = int'(pkt[0][27:24]);
    if (pkt[0][31:28] != 4'd4 || ihl < 5) return 0;
    if (n < ihl) return 0;
    if (hsum(ihl) != 16'hFFFF) return 2;
    if (n == ihl) return 0;
    if (pkt[1][13] || pkt[1][12:0] != 13'd0) return 0;
    if (pkt[2][23:16] == 8'd41 && pkt[4] == live) return 1;
    return 0;
  endfunction

  task automatic build(int ihl, logic [7:0] proto, logic [31:0] dst, logic [15:0] fragw,
                       int pay, bit bad);
    logic [31:0] t;
    int tot = (ihl + pay) * 4;
    pkt.delete();
    pkt.push_back({4'd4, 4'(ihl), 8'h00, 16'(tot)});
    pkt.push_back({16'h1234, fragw});
    pkt.push_back({8'd64, proto, 16'h0000});
    pkt.push_back(32'hC633_6401);
    pkt.push_back(dst);
    for (int i = 5; i < ihl; i++) pkt.push_back({16'h0101, 16'(i * 257)});
    t = pkt[2];
    t[15:0] = ~hsum(ihl);
    if (bad) t[31:24] = t[31:24] ^ 8'h01;
    pkt[2] = t;
    for (int k = 0; k < pay; k++) pkt.push_back(32'h6000_0000 + 32'(k * 32'h0011_0203));
  endtask

  task automatic put(int k, logic [31:0] d, bit s, bit e, logic [2:0] c);
    if (k < NC) begin
      ev[k] = 1'b1; ed[k] = d; es[k] = s; ee[k] = e; ec[k] = c;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0;
  endtask

  task automatic cfg(logic [31:0] v);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    cfg_we = 1; cfg_addr = v; m_pend = v;
  endtask

  task automatic send(int last_cnt, int gap, bit do_cfg = 0, logic [31:0] cfg_v = '0);
    int v = 0, ihl = 0;
    int n = pkt.size();
    logic [2:0] c;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c = (i == n - 1) ? 3'(last_cnt) : 3'd4;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_bcnt = c; in_data = pkt[i]; cfg_we = 0;
      if (i == 0) begin
        m_live = m_pend;
        if (do_cfg) begin cfg_we = 1; cfg_addr = cfg_v; m_pend = cfg_v; end
        v = verdict(m_live);
        ihl = int'(pkt[0][27:24]);
        if (v == 2 && m_err < MAXE) m_err++;
      end
      if (v == 0) put(cyc + 1 + LAT, pkt[i], i == 0, i == n - 1, c);
      else if (v == 1 && i >= ihl) put(cyc + 1 + LAT, pkt[i], i == ihl, i == n - 1, c);
    end
    repeat (gap) idle();
  endtask

  task automatic check_err(string tag);
    n_chk++;
    if (int'(err_count) != m_err) begin
      n_bad++;
      $display("FAIL %s err_count: got %0d expected %0d", tag, err_count, m_err);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL R9 watchdog expired: got hung run, expected completion");
    summary();
    $finish;
  end

  initial begin
    in_valid = 0; in_sof = 0; in_eof = 0; in_bcnt = 3'd4; in_data = '0;
    cfg_we = 0; cfg_addr = '0;
    m_pend = ADDR0; m_live = ADDR0; m_err = 0;
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    chk_on = 1;
    @(negedge clk);
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 out_valid: got %0b expected 0", out_valid);
    end
    check_err("R1");

    phase = "R2";
    build(5, 8'd41, ADDR0, 16'h0000, 6, 0); send(3, 2);
    build(5, 8'd41, ADDR0, 16'h0000, 1, 0); send(1, 3);

    phase = "R3";
    build(7, 8'd41, ADDR0, 16'h4000, 4, 0); send(4, 1);
    build(15, 8'd41, ADDR0, 16'h0000, 3, 0); send(2, 2);

    phase = "R4";
    build(5, 8'd6, ADDR0, 16'h0000, 4, 0); send(4, 1);

    phase = "R5";
    build(5, 8'd41, ADDR0 ^ 32'h1, 16'h0000, 4, 0); send(2, 1);

    phase = "R6";
    build(5, 8'd41, ADDR0, 16'h2000, 3, 0); send(4, 1);
    build(5, 8'd41, ADDR0, 16'h0005, 3, 0); send(4, 1);

    phase = "R7";
    build(5, 8'd41, ADDR0, 16'h0000, 3, 1); send(4, 1);
    build(6, 8'd6, ADDR0, 16'h0000, 2, 1); send(4, 1);
    repeat (LAT + 3) idle();
    check_err("R7");
    build(5, 8'd41, ADDR0, 16'h0000, 2, 1); send(4, 0);
    build(5, 8'd41, ADDR0, 16'h0000, 2, 1); send(4, 0);
    build(5, 8'd41, ADDR0, 16'h0000, 2, 0); send(4, 2);
    repeat (LAT + 3) idle();
    check_err("R7");

    phase = "R8";
    build(5, 8'd41, ADDR0, 16'h0000, 3, 0);
    pkt[0] = {4'd6, pkt[0][27:0]}; send(4, 1);
    pkt.delete();
    pkt.push_back({4'd4, 4'd3, 24'h000010});
    pkt.push_back(32'h1111_2222); pkt.push_back(32'h3333_4444); pkt.push_back(32'h5555_6666);
    send(4, 1);
    build(6, 8'd41, ADDR0, 16'h0000, 0, 0);
    void'(pkt.pop_back()); void'(pkt.pop_back());
    send(4, 1);
    build(5, 8'd41, ADDR0, 16'h0000, 0, 0); send(4, 1);
    build(5, 8'd41, ADDR0, 16'h0000, 0, 1); send(4, 1);

    phase = "R10";
    cfg(32'h0A00_00FE);
    build(5, 8'd41, ADDR0, 16'h0000, 2, 0); send(4, 1);
    build(5, 8'd41, 32'h0A00_00FE, 16'h0000, 2, 0); send(4, 1);
    build(5, 8'd41, 32'h0A00_00FE, 16'h0000, 2, 0); send(4, 0, 1, 32'h0A00_0077);
    build(5, 8'd41, 32'h0A00_0077, 16'h0000, 2, 0); send(3, 0);
    build(5, 8'd41, 32'h0A00_00FE, 16'h0000, 2, 0); send(4, 2);

    phase = "R11";
    for (int r = 0; r < 3; r++) begin
      pkt.delete(); pkt.push_back(32'h6ABC_0000 + 32'(r)); send(2, 0);
      build(5, 8'd41, 32'h0A00_0077, 16'h0000, 1, 0); send(1, 0);
      pkt.delete(); pkt.push_back({4'd4, 4'd5, 24'(r)}); send(4, 0);
      build(6, 8'd41, 32'h0A00_0077, 16'h0000, 2, r == 1); send(3, 0);
      build(5, 8'd17, 32'h0A00_0077, 16'h0000, 1, 0); send(4, 0);
    end
    repeat (LAT + 5) idle();
    check_err("R11");

    chk_on = 0;
    summary();
    $finish;
  end
endmodule